// File: doc/BRIEF.md
# Carry-Moded ALU with Condition Generator

This block is the arithmetic heart of an execution stage. On each clock it combines a left and a right operand under a 4-bit opcode. In the same cycle it evaluates one of sixteen condition selects against that operation. The result word, the condition flag and the pending carry are registered and appear one clock later.

The block keeps a single stored carry bit. Each add/subtract variant treats that bit in its own way: it may chain it in and out, chain it in and then clear it, ignore it and leave it alone, or ignore it and clear it. At the clock edge the pending carry moves into the stored carry, but only when the operation was not rejected by the surrounding pipeline and its selected condition did not raise a trap. A bounds-check opcode subtracts for the flags but passes the left operand through as its result. The condition selects include signed compares, overflow, bounds, a kernel-address fault check and a tag check on the top bits of each word.

Top module: `alu_cond_unit`

## Requirements
- R1: Outputs are registered one clock after the inputs. Adds give left+right+cin modulo 2^WIDTH, with the flag set to the adder carry-out. Subtracts give left+NOT right+NOT bin, which equals left-right-bin, with the flag set to the borrow, the inverse of the adder carry-out.
- R2: Opcodes 0 (signed add) and 1 (signed subtract) use the stored carry as cin or bin. Their pending carry is 0.
- R3: Opcodes 2 (unsigned add) and 3 (unsigned subtract) use the stored carry as cin or bin. Their pending carry equals the flag.
- R4: Opcodes 4 (plain add, cin 0) and 5 (plain subtract, bin 0) give a pending carry equal to the stored carry.
- R5: Opcodes 6 (add) and 7 (subtract) ignore the stored carry, using cin 0 or bin 0. Their pending carry is 0.
- R6: Opcodes 8, 9 and 10 give bitwise AND, OR and XOR. Opcodes 12 to 15 give result 0. All of these have flag 0, and their pending carry equals the stored carry.
- R7: Opcode 11 (bounds check) outputs the unchanged left operand. Its flag is the borrow of left-right with bin 0, and its pending carry equals the stored carry.
- R8: Select 0 and selects 14 and 15 give 0. Select 13 gives 1. Select 1 is result==0 and select 2 is result!=0.
- R9: With lt = flag XOR (left msb XOR right msb), the selects are: 3 is lt, 4 is NOT lt, 5 is lt OR result==0, and 6 is the inverse of select 5.
- R10: Select 7 is (flag XOR result msb) XOR (left msb XOR right msb).
- R11: Select 8 is NOT flag and select 9 is flag.
- R12: Select 10 is true when the top 3 bits of left, right or result are neither all zero nor all one. Select 11 is its inverse.
- R13: Select 12 is true when the result, taken as unsigned, is below the KERNEL_LIMIT parameter.
- R14: Synchronous reset clears all outputs. The stored carry (carry_o) takes the pending carry at the edge only when reject_i is low and the condition for that cycle is 0; otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| cond_sel_i | input | 4 | Condition select |
| left_i | input | WIDTH | Left operand |
| right_i | input | WIDTH | Right operand |
| reject_i | input | 1 | Suppresses the carry commit for this cycle's operation |
| result_o | output | WIDTH | Registered result |
| cond_o | output | 1 | Registered condition flag |
| carry_next_o | output | 1 | Registered pending carry of the last operation |
| carry_o | output | 1 | Stored carry register |

## Verification
The bench builds the block with WIDTH=8 and KERNEL_LIMIT=8'h40. At that width the 3-bit tag field and the sign bit are only a few steps apart in the operand space, and adder wrap-around and borrow chains come up often. This lets a dense grid of operands cover all sixteen opcodes and all sixteen condition selects while the reject input toggles. A model of the stored carry kept inside the bench follows every commit and every hold, so chained carries and carries blocked by a trap are checked across long runs of operations.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;

  localparam logic [3:0] OP_SADD  = 4'd0;
  localparam logic [3:0] OP_SSUB  = 4'd1;
  localparam logic [3:0] OP_UADD  = 4'd2;
  localparam logic [3:0] OP_USUB  = 4'd3;
  localparam logic [3:0] OP_VADD  = 4'd4;
  localparam logic [3:0] OP_VSUB  = 4'd5;
  localparam logic [3:0] OP_LADD  = 4'd6;
  localparam logic [3:0] OP_LSUB  = 4'd7;
  localparam logic [3:0] OP_AND   = 4'd8;
  localparam logic [3:0] OP_OR    = 4'd9;
  localparam logic [3:0] OP_XOR   = 4'd10;
  localparam logic [3:0] OP_BOUND = 4'd11;

  localparam logic [3:0] CS_NEVER  = 4'd0;
  localparam logic [3:0] CS_ZERO   = 4'd1;
  localparam logic [3:0] CS_NZERO  = 4'd2;
  localparam logic [3:0] CS_LT     = 4'd3;
  localparam logic [3:0] CS_GE     = 4'd4;
  localparam logic [3:0] CS_LE     = 4'd5;
  localparam logic [3:0] CS_GT     = 4'd6;
  localparam logic [3:0] CS_OVF    = 4'd7;
  localparam logic [3:0] CS_INBND  = 4'd8;
  localparam logic [3:0] CS_OUTBND = 4'd9;
  localparam logic [3:0] CS_TAG    = 4'd10;
  localparam logic [3:0] CS_NTAG   = 4'd11;
  localparam logic [3:0] CS_KFAULT = 4'd12;
  localparam logic [3:0] CS_ALWAYS = 4'd13;

  typedef enum logic [2:0] {K_ARITH, K_BOUND, K_AND, K_OR, K_XOR, K_NONE} res_kind_e;
  typedef enum logic [1:0] {P_HOLD, P_CLEAR, P_FLAG} pend_sel_e;

  typedef struct packed {
    res_kind_e kind;
    logic      sub;
    logic      use_stored;
    pend_sel_e pend;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [3:0] op);
    op_dec_t d;
    d = '{kind: K_NONE, sub: 1'b0, use_stored: 1'b0, pend: P_HOLD};
    case (op)
      OP_SADD:  d = '{kind: K_ARITH, sub: 1'b0, use_stored: 1'b1, pend: P_CLEAR};
      OP_SSUB:  d = '{kind: K_ARITH, sub: 1'b1, use_stored: 1'b1, pend: P_CLEAR};
      OP_UADD:  d = '{kind: K_ARITH, sub: 1'b0, use_stored: 1'b1, pend: P_FLAG};
      OP_USUB:  d = '{kind: K_ARITH, sub: 1'b1, use_stored: 1'b1, pend: P_FLAG};
      OP_VADD:  d = '{kind: K_ARITH, sub: 1'b0, use_stored: 1'b0, pend: P_HOLD};
      OP_VSUB:  d = '{kind: K_ARITH, sub: 1'b1, use_stored: 1'b0, pend: P_HOLD};
      OP_LADD:  d = '{kind: K_ARITH, sub: 1'b0, use_stored: 1'b0, pend: P_CLEAR};
      OP_LSUB:  d = '{kind: K_ARITH, sub: 1'b1, use_stored: 1'b0, pend: P_CLEAR};
      OP_AND:   d.kind = K_AND;
      OP_OR:    d.kind = K_OR;
      OP_XOR:   d.kind = K_XOR;
      OP_BOUND: d = '{kind: K_BOUND, sub: 1'b1, use_stored: 1'b0, pend: P_HOLD};
      default:  d.kind = K_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_cond_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] left,
  input  logic [WIDTH-1:0] right,
  input  logic             stored_carry,
  output logic [WIDTH-1:0] res,
  output logic             flag,
  output logic             pend
);
  localparam int SUMW = WIDTH + 1;

  op_dec_t          dec;
  logic [WIDTH-1:0] rhs;
  logic             cin;
  logic [SUMW-1:0]  total;
  logic             uses_adder;

  assign dec        = decode_op(op);
  assign rhs        = dec.sub ? ~right : right;
  assign uses_adder = (dec.kind == K_ARITH) || (dec.kind == K_BOUND);

  // borrow-in is the stored carry, expressed to the adder as its inverse
  always_comb begin
    if (dec.use_stored) cin = dec.sub ? ~stored_carry : stored_carry;
    else                cin = dec.sub;
  end

  assign total = {1'b0, left} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};
  assign flag  = uses_adder & (dec.sub ? ~total[SUMW-1] : total[SUMW-1]);

  always_comb begin
    case (dec.kind)
      K_ARITH: res = total[WIDTH-1:0];
      K_BOUND: res = left;
      K_AND:   res = left & right;
      K_OR:    res = left | right;
      K_XOR:   res = left ^ right;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (dec.pend)
      P_CLEAR: pend = 1'b0;
      P_FLAG:  pend = flag;
      default: pend = stored_carry;
    endcase
  end
endmodule

// File: rtl/alu_cond_gen.sv
module alu_cond_gen
  import alu_cond_pkg::*;
#(
  parameter int               WIDTH        = 32,
  parameter int               TAG_BITS     = 3,
  parameter logic [WIDTH-1:0] KERNEL_LIMIT = WIDTH'(32'h0000_0400)
) (
  input  logic [3:0]       sel,
  input  logic [WIDTH-1:0] left,
  input  logic [WIDTH-1:0] right,
  input  logic [WIDTH-1:0] res,
  input  logic             flag,
  output logic             cond
);
  localparam int NPROBE = 3;
  localparam int MSB    = WIDTH - 1;

  logic [WIDTH-1:0]  probe [NPROBE];
  logic [NPROBE-1:0] tag_bad;
  logic              is_zero, lt, le, ovf, any_tag;

  assign probe[0] = left;
  assign probe[1] = right;
  assign probe[2] = res;

  for (genvar g = 0; g < NPROBE; g++) begin : g_tag
    logic [TAG_BITS-1:0] top;
    assign top        = probe[g][MSB -: TAG_BITS];
    assign tag_bad[g] = (|top) & ~(&top);
  end

  assign any_tag = |tag_bad;
  assign is_zero = (res == '0);
  assign lt      = flag ^ (left[MSB] ^ right[MSB]);
  assign le      = lt | is_zero;
  assign ovf     = (flag ^ res[MSB]) ^ (left[MSB] ^ right[MSB]);

  always_comb begin
    case (sel)
      CS_ZERO:   cond = is_zero;
      CS_NZERO:  cond = ~is_zero;
      CS_LT:     cond = lt;
      CS_GE:     cond = ~lt;
      CS_LE:     cond = le;
      CS_GT:     cond = ~le;
      CS_OVF:    cond = ovf;
      CS_INBND:  cond = ~flag;
      CS_OUTBND: cond = flag;
      CS_TAG:    cond = any_tag;
      CS_NTAG:   cond = ~any_tag;
      CS_KFAULT: cond = (res < KERNEL_LIMIT);
      CS_ALWAYS: cond = 1'b1;
      default:   cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_carry_ctl.sv
module alu_carry_ctl (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic reject,
  input  logic trap,
  output logic carry_q
);
  always_ff @(posedge clk) begin
    if (rst)                  carry_q <= 1'b0;
    else if (!reject && !trap) carry_q <= pend;
  end
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit #(
  parameter int               WIDTH        = 32,
  parameter int               TAG_BITS     = 3,
  parameter logic [WIDTH-1:0] KERNEL_LIMIT = WIDTH'(32'h0000_0400)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [3:0]       cond_sel_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  input  logic             reject_i,
  output logic [WIDTH-1:0] result_o,
  output logic             cond_o,
  output logic             carry_next_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] res_c;
  logic             flag_c, pend_c, cond_c;

  alu_arith_core #(.WIDTH(WIDTH)) core_i (
    .op(op_i), .left(left_i), .right(right_i), .stored_carry(carry_o),
    .res(res_c), .flag(flag_c), .pend(pend_c)
  );

  alu_cond_gen #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS), .KERNEL_LIMIT(KERNEL_LIMIT)) cgen_i (
    .sel(cond_sel_i), .left(left_i), .right(right_i), .res(res_c),
    .flag(flag_c), .cond(cond_c)
  );

  alu_carry_ctl carry_i (
    .clk(clk), .rst(rst), .pend(pend_c), .reject(reject_i), .trap(cond_c),
    .carry_q(carry_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o     <= '0;
      cond_o       <= 1'b0;
      carry_next_o <= 1'b0;
    end else begin
      result_o     <= res_c;
      cond_o       <= cond_c;
      carry_next_o <= pend_c;
    end
  end
endmodule

// File: rtl/alu_cond_unit_chk.sv
module alu_cond_unit_chk
  import alu_cond_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_i,
  input logic [3:0]       cond_sel_i,
  input logic [WIDTH-1:0] left_i,
  input logic             reject_i,
  input logic [WIDTH-1:0] result_o,
  input logic             cond_o,
  input logic             carry_next_o,
  input logic             carry_o
);
  p_bound_passes_left_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_BOUND) |=> (result_o == $past(left_i)));

  p_clear_variants_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LADD || op_i == OP_LSUB) |=> !carry_next_o);

  p_signed_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SADD || op_i == OP_SSUB) |=> !carry_next_o);

  p_plain_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_VADD || op_i == OP_VSUB) |=> (carry_next_o == $past(carry_o)));

  p_never_always_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_sel_i == CS_NEVER) |=> !cond_o);

  p_always_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_sel_i == CS_ALWAYS) |=> cond_o);

  p_reject_holds_r14: assert property (@(posedge clk) disable iff (rst)
    reject_i |=> $stable(carry_o));

  p_trap_holds_r14: assert property (@(posedge clk) disable iff (rst)
    cond_o |-> $stable(carry_o));

  p_commit_r14: assert property (@(posedge clk) disable iff (rst)
    (!$past(reject_i) && !cond_o) |-> (carry_o == carry_next_o));
endmodule

bind alu_cond_unit alu_cond_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .op_i(op_i), .cond_sel_i(cond_sel_i), .left_i(left_i),
  .reject_i(reject_i), .result_o(result_o), .cond_o(cond_o),
  .carry_next_o(carry_next_o), .carry_o(carry_o)
);

// File: tb/alu_cond_unit_tb_top.sv
`timescale 1ns/1ps
module alu_cond_unit_tb_top;
  localparam int BW   = 8;
  localparam int KLIM = 8'h40;
  localparam int MAXC = 200000;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    op_i, cond_sel_i;
  logic [BW-1:0] left_i, right_i;
  logic          reject_i;
  logic [BW-1:0] result_o;
  logic          cond_o, carry_next_o, carry_o;

  int checks = 0;
  int failures = 0;
  int mc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_cond_unit #(.WIDTH(BW), .TAG_BITS(3), .KERNEL_LIMIT(8'h40)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .cond_sel_i(cond_sel_i),
    .left_i(left_i), .right_i(right_i), .reject_i(reject_i),
    .result_o(result_o), .cond_o(cond_o), .carry_next_o(carry_next_o),
    .carry_o(carry_o)
  );

  function automatic string op_tag(int op);
    if (op <= 1)  return "R2";
    if (op <= 3)  return "R3";
    if (op <= 5)  return "R4";
    if (op <= 7)  return "R5";
    if (op == 11) return "R7";
    return "R6";
  endfunction

  function automatic string cs_tag(int cs);
    case (cs)
      3, 4, 5, 6: return "R9";
      7:          return "R10";
      8, 9:       return "R11";
      10, 11:     return "R12";
      12:         return "R13";
      default:    return "R8";
    endcase
  endfunction

  function automatic bit tag_bad(int x);
    int t;
    t = (x >> 5) & 7;
    return (t != 0) && (t != 7);
  endfunction

  task automatic model(input int op, input int cs, input int l, input int r, input int c,
                       output int res, output int f, output int pend, output int cnd);
    int s, sl, sr, sres, lt, z;
    res = 0; f = 0; pend = c;
    case (op)
      0, 2, 4, 6: begin
        s = l + r + (((op == 0) || (op == 2)) ? c : 0);
        res = s & 255; f = (s >> 8) & 1;
        pend = (op == 2) ? f : ((op == 4) ? c : 0);
      end
      1, 3, 5, 7, 11: begin
        s = l - r - (((op == 1) || (op == 3)) ? c : 0);
        res = (op == 11) ? l : (s & 255); f = (s < 0) ? 1 : 0;
        pend = (op == 3) ? f : ((op == 1 || op == 7) ? 0 : c);
      end
      8:  res = l & r;
      9:  res = l | r;
      10: res = l ^ r;
      default: res = 0;
    endcase
    sl = (l >> 7) & 1; sr = (r >> 7) & 1; sres = (res >> 7) & 1;
    lt = f ^ sl ^ sr; z = (res == 0) ? 1 : 0;
    case (cs)
      1: cnd = z;
      2: cnd = 1 - z;
      3: cnd = lt;
      4: cnd = 1 - lt;
      5: cnd = lt | z;
      6: cnd = 1 - (lt | z);
      7: cnd = (f ^ sres) ^ (sl ^ sr);
      8: cnd = 1 - f;
      9: cnd = f;
      10: cnd = (tag_bad(l) || tag_bad(r) || tag_bad(res)) ? 1 : 0;
      11: cnd = (tag_bad(l) || tag_bad(r) || tag_bad(res)) ? 0 : 1;
      12: cnd = (res < KLIM) ? 1 : 0;
      13: cnd = 1;
      default: cnd = 0;
    endcase
  endtask

  task automatic step(input int op, input int cs, input int l, input int r, input bit rej);
    int er, ef, ep, ec;
    model(op, cs, l, r, mc, er, ef, ep, ec);
    op_i = 4'(op); cond_sel_i = 4'(cs); left_i = BW'(l); right_i = BW'(r); reject_i = rej;
    @(posedge clk);
    @(negedge clk);
    if (!rej && ec == 0) mc = ep;
    checks += 4;
    if (result_o !== BW'(er)) begin
      failures++;
      $display("FAIL %s op=%0d result act=%0h exp=%0h", (op <= 7) ? "R1" : op_tag(op), op, result_o, er);
    end
    if (cond_o !== 1'(ec)) begin
      failures++;
      $display("FAIL %s sel=%0d op=%0d l=%0h r=%0h cond act=%0b exp=%0d", cs_tag(cs), cs, op, l, r, cond_o, ec);
    end
    if (carry_next_o !== 1'(ep)) begin
      failures++;
      $display("FAIL %s op=%0d pending carry act=%0b exp=%0d", op_tag(op), op, carry_next_o, ep);
    end
    if (carry_o !== 1'(mc)) begin
      failures++;
      $display("FAIL R14 stored carry act=%0b exp=%0d", carry_o, mc);
    end
  endtask

  initial begin
    rst = 1'b1; op_i = '0; cond_sel_i = '0; left_i = '0; right_i = '0; reject_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R14: reset state
    checks++;
    if (result_o !== '0 || cond_o !== 1'b0 || carry_next_o !== 1'b0 || carry_o !== 1'b0) begin
      failures++;
      $display("FAIL R14 reset outputs act=%0h/%0b/%0b/%0b exp=0/0/0/0",
               result_o, cond_o, carry_next_o, carry_o);
    end
    rst = 1'b0;
    mc = 0;

    // R3: unsigned add wraps and chains carry into the next add
    step(2, 0, 8'hFF, 8'h01, 1'b0);
    step(2, 1, 8'h10, 8'h20, 1'b0);
    // R14: trap via always-select blocks the commit, reject also blocks it
    step(3, 13, 8'h00, 8'h01, 1'b0);
    step(3, 0, 8'h00, 8'h01, 1'b1);
    step(3, 0, 8'h00, 8'h01, 1'b0);
    // R2: signed subtract consumes borrow and clears it
    step(1, 3, 8'h05, 8'h05, 1'b0);
    // R7: bounds check passes left, flag via select 9
    step(11, 9, 8'h03, 8'h09, 1'b0);
    // R13: kernel fault boundary at the limit
    step(4, 12, 8'h3F, 8'h00, 1'b0);
    step(4, 12, 8'h40, 8'h00, 1'b0);
    // R10: signed overflow 0x7F+1
    step(6, 7, 8'h7F, 8'h01, 1'b0);

    // Grid sweep over every opcode and select with toggled reject
    for (int op = 0; op < 16; op++)
      for (int l = 0; l < 256; l += 15)
        for (int r = 0; r < 256; r += 13)
          step(op, (l / 15 + r / 13 + op) % 16, l, r, ((l ^ r) & 4) != 0);

    // Exhaustive left operand for tag and compare selects
    for (int l = 0; l < 256; l++) begin
      step(5, 10 + (l % 2), l, 8'h20, 1'b0);
      step(1, 3 + (l % 4), l, 8'h80, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (MAXC) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule